// File: doc/BRIEF.md
# Pipelined Eleven-Bit Floating-Point Adder/Subtractor

This block adds or subtracts two numbers held in a compact eleven-bit floating-point code. Bit 10 is the sign (1 means negative). Bits 9..6 are an exponent stored with an offset of 7. Bits 5..0 are the fraction, with an implied leading one in front of it. Exponent code 0 stands for zero whatever the fraction holds. Exponent code 15 is never produced as a finite result. Denormal values do not exist in this code.

The work is spread over four registered stages. The first aligns the operands: the one with the smaller exponent is shifted right, and three extra bits below the fraction are kept for guard, round and sticky. The second adds or subtracts the significands. The third normalizes the sum and detects underflow. The fourth rounds to nearest with ties to even, renormalizes if the rounding carries out, and detects overflow.

The pipeline takes a new operation on every cycle. A pulse on the input valid line reappears on the output valid line four cycles later, together with the result and its two flags.

Top module: `minifloat_addsub`

## Requirements
- R1: An operand whose exponent field (bits 9..6) is 0 is taken as zero, even if its fraction bits are nonzero.
- R2: When `op_sub` is 1 the block computes a − b by inverting the sign of b. The sign of a nonzero result is the sign of the operand with the larger magnitude.
- R3: `out_valid` rises exactly four clock cycles after `in_valid` is sampled high. Operations issued on consecutive cycles emerge on consecutive cycles, in order.
- R4: The operand with the smaller exponent is shifted right by the exponent difference. Bits shifted past the guard and round positions are ORed into a sticky bit. A shift as wide as the extended significand or wider leaves only the sticky bit.
- R5: A sum that carries out is shifted right by one and its exponent is raised by one. A difference with leading zeros is shifted left until its top bit is one, and its exponent is lowered by the same amount.
- R6: Rounding is to nearest. An exact halfway case goes to the neighbour whose fraction LSB (bit 0) is 0.
- R7: If rounding carries out of the significand, the result is renormalized to fraction 0 and the exponent is raised by one.
- R8: If the final exponent reaches 15 or more, the result is the sign, exponent 15 and fraction 0, with `ovf_flag` set. An in-range result never carries exponent code 15.
- R9: If a nonzero result's exponent falls below 1, the result is the signed zero (sign kept, bits 9..0 cleared), with `unf_flag` set.
- R10: An exact zero sum, including zero plus zero, returns +0 (all bits 0) with both flags clear.
- R11: While `rst_n` is low on a clock edge, `out_valid`, `result` and both flags are cleared, and operations in flight are dropped.
- R12: `result`, `ovf_flag` and `unf_flag` keep their values in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| op_sub | input | 1 | 1 = subtract b from a, 0 = add |
| opnd_a | input | 11 | First operand |
| opnd_b | input | 11 | Second operand |
| out_valid | output | 1 | Result and flags are new this cycle |
| result | output | 11 | Rounded sum or difference |
| ovf_flag | output | 1 | Exponent overflow occurred |
| unf_flag | output | 1 | Exponent underflow occurred, result flushed to zero |

## Verification
The cases that are hardest to reach from the ports are those decided by the bits below the fraction. These are exact ties, ties that carry the significand into the next binade, and a carry that pushes an already maximal exponent into overflow. The stimulus sets the exponent gap to exactly seven, so the smaller operand's leading one lands on the guard position alone, or together with a lower bit that must end up in the sticky bit. A subtraction of two operands one ulp apart drives the normalizer's left shift past the smallest exponent, which brings about underflow of either sign.

// File: rtl/mfa_pkg.sv
// Package: default format widths and the shared rounding decision.
// Assumes three extra bits (guard, round, sticky) below the fraction.
package mfa_pkg;
    localparam int MFA_EXP_W  = 4;
    localparam int MFA_FRAC_W = 6;
    localparam int MFA_GRS_W  = 3;

    // Round-to-nearest-even increment decision.
    function automatic logic rne_inc(input logic lsb, input logic g,
                                     input logic r, input logic s);
        return g & (r | s | lsb);
    endfunction
endpackage

// File: rtl/mfa_align.sv
// Stage 1: unpack both operands, pick the larger magnitude, and shift the
// smaller significand right by the exponent gap, keeping guard, round and
// sticky bits. Assumes exponent code 0 means zero and no denormals exist.
module mfa_align #(
    parameter int EXP_W  = mfa_pkg::MFA_EXP_W,
    parameter int FRAC_W = mfa_pkg::MFA_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1,
    localparam int GRS_W = mfa_pkg::MFA_GRS_W,
    localparam int EXT_W = SIG_W + GRS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             op_sub,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    output logic             v1,
    output logic [EXT_W-1:0] big1,
    output logic [EXT_W-1:0] sml1,
    output logic [EXP_W-1:0] exp1,
    output logic             sign1,
    output logic             sub1
);
    logic             sa, sb, za, zb, a_big;
    logic [EXP_W-1:0] ea, eb, e_big, e_sml, gap;
    logic [W-2:0]     ka, kb;
    logic [SIG_W-1:0] siga, sigb, sig_big, sig_sml;
    logic [2*EXT_W-1:0] wide;
    logic             stk;
    logic [EXT_W-1:0] sml_c;

    // Unpack operands and order them by magnitude.
    always_comb begin
        sa    = opnd_a[W-1];
        sb    = opnd_b[W-1] ^ op_sub;
        ea    = opnd_a[W-2:FRAC_W];
        eb    = opnd_b[W-2:FRAC_W];
        za    = (ea == '0);
        zb    = (eb == '0);
        siga  = za ? '0 : {1'b1, opnd_a[FRAC_W-1:0]};
        sigb  = zb ? '0 : {1'b1, opnd_b[FRAC_W-1:0]};
        ka    = za ? '0 : opnd_a[W-2:0];
        kb    = zb ? '0 : opnd_b[W-2:0];
        a_big = (ka >= kb);
        e_big   = a_big ? ea : eb;
        e_sml   = a_big ? eb : ea;
        sig_big = a_big ? siga : sigb;
        sig_sml = a_big ? sigb : siga;
        gap     = e_big - e_sml;
    end

    // Right-shift the smaller significand, folding lost bits into sticky.
    always_comb begin
        wide = {sig_sml, {GRS_W{1'b0}}, {EXT_W{1'b0}}} >> gap;
        if (int'(gap) >= EXT_W) begin
            stk   = |sig_sml;
            sml_c = {{(EXT_W-1){1'b0}}, stk};
        end else begin
            stk   = |wide[EXT_W-1:0];
            sml_c = wide[2*EXT_W-1:EXT_W] | {{(EXT_W-1){1'b0}}, stk};
        end
    end

    // Stage register; data loads only with a valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; big1 <= '0; sml1 <= '0; exp1 <= '0;
            sign1 <= 1'b0; sub1 <= 1'b0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                big1  <= {sig_big, {GRS_W{1'b0}}};
                sml1  <= sml_c;
                exp1  <= e_big;
                sign1 <= a_big ? sa : sb;
                sub1  <= sa ^ sb;
            end
        end
    end
endmodule

// File: rtl/mfa_addsig.sv
// Stage 2: add or subtract the aligned extended significands.
// Assumes the first operand is never smaller in magnitude than the second,
// so a difference is never negative.
module mfa_addsig #(
    parameter int EXP_W  = mfa_pkg::MFA_EXP_W,
    parameter int FRAC_W = mfa_pkg::MFA_FRAC_W,
    localparam int EXT_W = FRAC_W + 1 + mfa_pkg::MFA_GRS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v1,
    input  logic [EXT_W-1:0] big1,
    input  logic [EXT_W-1:0] sml1,
    input  logic [EXP_W-1:0] exp1,
    input  logic             sign1,
    input  logic             sub1,
    output logic             v2,
    output logic [EXT_W:0]   sum2,
    output logic [EXP_W-1:0] exp2,
    output logic             sign2
);
    logic [EXT_W:0] sum_c;

    // Significand adder/subtractor.
    always_comb begin
        if (sub1) sum_c = {1'b0, big1} - {1'b0, sml1};
        else      sum_c = {1'b0, big1} + {1'b0, sml1};
    end

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2 <= 1'b0; sum2 <= '0; exp2 <= '0; sign2 <= 1'b0;
        end else begin
            v2 <= v1;
            if (v1) begin
                sum2  <= sum_c;
                exp2  <= exp1;
                sign2 <= sign1;
            end
        end
    end
endmodule

// File: rtl/mfa_norm.sv
// Stage 3: normalize the raw sum (right by one on carry-out, or left by the
// leading-zero count), adjust the exponent, and flag zero and underflow.
// Assumes the sticky bit stays in the LSB when shifting right.
module mfa_norm #(
    parameter int EXP_W  = mfa_pkg::MFA_EXP_W,
    parameter int FRAC_W = mfa_pkg::MFA_FRAC_W,
    localparam int EXT_W  = FRAC_W + 1 + mfa_pkg::MFA_GRS_W,
    localparam int EXPI_W = EXP_W + 2,
    localparam int LZ_W   = $clog2(EXT_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v2,
    input  logic [EXT_W:0]           sum2,
    input  logic [EXP_W-1:0]         exp2,
    input  logic                     sign2,
    output logic                     v3,
    output logic [EXT_W-1:0]         nrm3,
    output logic signed [EXPI_W-1:0] exp3,
    output logic                     sign3,
    output logic                     zero3,
    output logic                     unf3
);
    logic [LZ_W-1:0]          lz;
    logic                     found;
    logic [EXT_W-1:0]         nrm_c;
    logic signed [EXPI_W-1:0] exp_c;
    logic                     zero_c, unf_c;

    // Leading-zero count over the non-carry part of the sum.
    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!found && sum2[i]) begin
                lz    = LZ_W'(EXT_W - 1 - i);
                found = 1'b1;
            end
        end
    end

    // Shift and exponent adjust, then zero and underflow detection.
    always_comb begin
        if (sum2[EXT_W]) begin
            nrm_c = sum2[EXT_W:1] | {{(EXT_W-1){1'b0}}, sum2[0]};
            exp_c = $signed(EXPI_W'(exp2)) + $signed(EXPI_W'(1));
        end else begin
            nrm_c = sum2[EXT_W-1:0] << lz;
            exp_c = $signed(EXPI_W'(exp2)) - $signed(EXPI_W'(lz));
        end
        zero_c = (sum2 == '0);
        unf_c  = !zero_c && (exp_c < $signed(EXPI_W'(1)));
    end

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v3 <= 1'b0; nrm3 <= '0; exp3 <= '0; sign3 <= 1'b0;
            zero3 <= 1'b0; unf3 <= 1'b0;
        end else begin
            v3 <= v2;
            if (v2) begin
                nrm3  <= nrm_c;
                exp3  <= exp_c;
                sign3 <= sign2;
                zero3 <= zero_c;
                unf3  <= unf_c;
            end
        end
    end
endmodule

// File: rtl/mfa_round.sv
// Stage 4: round to nearest even, renormalize on carry-out, detect overflow,
// and pack the output word with its flags. Assumes a normalized input whose
// top bit is one unless the zero or underflow flag is set.
module mfa_round #(
    parameter int EXP_W  = mfa_pkg::MFA_EXP_W,
    parameter int FRAC_W = mfa_pkg::MFA_FRAC_W,
    localparam int W      = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int GRS_W  = mfa_pkg::MFA_GRS_W,
    localparam int EXT_W  = SIG_W + GRS_W,
    localparam int EXPI_W = EXP_W + 2,
    localparam int EMAX   = (1 << EXP_W) - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v3,
    input  logic [EXT_W-1:0]         nrm3,
    input  logic signed [EXPI_W-1:0] exp3,
    input  logic                     sign3,
    input  logic                     zero3,
    input  logic                     unf3,
    output logic                     out_valid,
    output logic [W-1:0]             result,
    output logic                     ovf_flag,
    output logic                     unf_flag
);
    logic                     up;
    logic [SIG_W:0]           rsum;
    logic [FRAC_W-1:0]        frac_r;
    logic signed [EXPI_W-1:0] exp_r;
    logic [W-1:0]             res_c;
    logic                     ovf_c, unf_c;

    // Rounding increment and renormalization.
    always_comb begin
        up   = mfa_pkg::rne_inc(nrm3[GRS_W], nrm3[2], nrm3[1], nrm3[0]);
        rsum = {1'b0, nrm3[EXT_W-1:GRS_W]} + (SIG_W+1)'(up);
        if (rsum[SIG_W]) begin
            frac_r = '0;
            exp_r  = exp3 + $signed(EXPI_W'(1));
        end else begin
            frac_r = rsum[FRAC_W-1:0];
            exp_r  = exp3;
        end
    end

    // Final packing with zero, underflow and overflow cases.
    always_comb begin
        ovf_c = 1'b0;
        unf_c = 1'b0;
        if (zero3) begin
            res_c = '0;
        end else if (unf3) begin
            res_c = {sign3, {(W-1){1'b0}}};
            unf_c = 1'b1;
        end else if (exp_r >= $signed(EXPI_W'(EMAX))) begin
            res_c = {sign3, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf_c = 1'b1;
        end else begin
            res_c = {sign3, exp_r[EXP_W-1:0], frac_r};
        end
    end

    // Output register; holds while no new result arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; result <= '0; ovf_flag <= 1'b0; unf_flag <= 1'b0;
        end else begin
            out_valid <= v3;
            if (v3) begin
                result   <= res_c;
                ovf_flag <= ovf_c;
                unf_flag <= unf_c;
            end
        end
    end
endmodule

// File: rtl/minifloat_addsub.sv
// Top: four-stage pipelined adder/subtractor for the eleven-bit float code
// (sign, offset-7 exponent, six fraction bits, hidden one). Accepts one
// operation per cycle; the result appears four cycles after the input.
module minifloat_addsub #(
    parameter int EXP_W  = mfa_pkg::MFA_EXP_W,
    parameter int FRAC_W = mfa_pkg::MFA_FRAC_W,
    localparam int W      = 1 + EXP_W + FRAC_W,
    localparam int EXT_W  = FRAC_W + 1 + mfa_pkg::MFA_GRS_W,
    localparam int EXPI_W = EXP_W + 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         op_sub,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         ovf_flag,
    output logic         unf_flag
);
    logic                     v1, v2, v3;
    logic [EXT_W-1:0]         big1, sml1, nrm3;
    logic [EXP_W-1:0]         exp1, exp2;
    logic                     sign1, sub1, sign2, sign3, zero3, unf3;
    logic [EXT_W:0]           sum2;
    logic signed [EXPI_W-1:0] exp3;

    mfa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .v1(v1), .big1(big1),
        .sml1(sml1), .exp1(exp1), .sign1(sign1), .sub1(sub1));

    mfa_addsig #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addsig (
        .clk(clk), .rst_n(rst_n), .v1(v1), .big1(big1), .sml1(sml1),
        .exp1(exp1), .sign1(sign1), .sub1(sub1), .v2(v2), .sum2(sum2),
        .exp2(exp2), .sign2(sign2));

    mfa_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .clk(clk), .rst_n(rst_n), .v2(v2), .sum2(sum2), .exp2(exp2),
        .sign2(sign2), .v3(v3), .nrm3(nrm3), .exp3(exp3), .sign3(sign3),
        .zero3(zero3), .unf3(unf3));

    mfa_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .clk(clk), .rst_n(rst_n), .v3(v3), .nrm3(nrm3), .exp3(exp3),
        .sign3(sign3), .zero3(zero3), .unf3(unf3), .out_valid(out_valid),
        .result(result), .ovf_flag(ovf_flag), .unf_flag(unf_flag));
endmodule

// File: rtl/mfa_checker.sv
// Checker: port-level properties of the adder pipeline, bound to the top.
// Assumes synchronous active-low reset.
module mfa_checker #(
    parameter int EXP_W  = mfa_pkg::MFA_EXP_W,
    parameter int FRAC_W = mfa_pkg::MFA_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         ovf_flag,
    input logic         unf_flag
);
    logic [2:0] since_rst;

    // Count edges since reset release, saturating at four.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4))); // R3
    AST_OVF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf_flag) |-> (result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})); // R8
    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !ovf_flag) |-> (result[W-2:FRAC_W] != {EXP_W{1'b1}})); // R8
    AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && unf_flag) |-> (result[W-2:0] == '0 && !ovf_flag)); // R9
    AST_ZERO_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !unf_flag && result[W-2:FRAC_W] == '0) |-> (result == '0)); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !out_valid) |-> ($stable(result) && $stable(ovf_flag) && $stable(unf_flag))); // R12
    AST_RESET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && !ovf_flag && !unf_flag)); // R11
endmodule

bind minifloat_addsub mfa_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mfa_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .result(result), .ovf_flag(ovf_flag), .unf_flag(unf_flag));

// File: tb/minifloat_addsub_test.sv
`timescale 1ns/1ps
module minifloat_addsub_test;
    typedef struct packed {
        logic        sub;
        logic [10:0] a;
        logic [10:0] b;
        logic [10:0] res;
        logic        ovf;
        logic        unf;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 11'h180, 11'h570, 11'h0C0, 1'b0, 1'b0, 4'd5},  // R5 0.5-0.4375
        '{1'b0, 11'h1C0, 11'h1C0, 11'h200, 1'b0, 1'b0, 4'd5},  // R5 carry-out
        '{1'b1, 11'h1C0, 11'h1C0, 11'h000, 1'b0, 1'b0, 4'd10}, // R10 x-x
        '{1'b0, 11'h200, 11'h040, 11'h200, 1'b0, 1'b0, 4'd6},  // R6 tie, even down
        '{1'b0, 11'h201, 11'h040, 11'h202, 1'b0, 1'b0, 4'd6},  // R6 tie, odd up
        '{1'b0, 11'h200, 11'h041, 11'h201, 1'b0, 1'b0, 4'd4},  // R4 sticky
        '{1'b0, 11'h23F, 11'h040, 11'h240, 1'b0, 1'b0, 4'd7},  // R7 round carry
        '{1'b0, 11'h3BF, 11'h3BF, 11'h3C0, 1'b1, 1'b0, 4'd8},  // R8 sum overflow
        '{1'b0, 11'h3BF, 11'h1C0, 11'h3C0, 1'b1, 1'b0, 4'd8},  // R8 overflow via rounding
        '{1'b1, 11'h041, 11'h040, 11'h000, 1'b0, 1'b1, 4'd9},  // R9 +underflow
        '{1'b1, 11'h040, 11'h041, 11'h400, 1'b0, 1'b1, 4'd9},  // R9 -underflow
        '{1'b0, 11'h03F, 11'h1C0, 11'h1C0, 1'b0, 1'b0, 4'd1},  // R1 code-0 exponent
        '{1'b1, 11'h1C0, 11'h200, 11'h5C0, 1'b0, 1'b0, 4'd2},  // R2 1-2
        '{1'b0, 11'h620, 11'h1C0, 11'h600, 1'b0, 1'b0, 4'd2},  // R2 -3+1
        '{1'b0, 11'h400, 11'h400, 11'h000, 1'b0, 1'b0, 4'd10}, // R10 -0 + -0
        '{1'b0, 11'h1E0, 11'h1D0, 11'h218, 1'b0, 1'b0, 4'd5},  // R5 1.5+1.25
        '{1'b0, 11'h3BF, 11'h040, 11'h3BF, 1'b0, 1'b0, 4'd4},  // R4 far shift
        '{1'b1, 11'h200, 11'h041, 11'h1FF, 1'b0, 1'b0, 4'd5},  // R5 left shift + sticky
        '{1'b0, 11'h000, 11'h5A5, 11'h5A5, 1'b0, 1'b0, 4'd1}   // R1 zero operand
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [10:0] opnd_a = '0;
    logic [10:0] opnd_b = '0;
    logic        out_valid, ovf_flag, unf_flag;
    logic [10:0] result;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    minifloat_addsub uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
        .result(result), .ovf_flag(ovf_flag), .unf_flag(unf_flag));

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic [10:0] a, input logic [10:0] b);
        in_valid = v; op_sub = s; opnd_a = a; opnd_b = b;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [10:0] held;
        bit          seen;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(out_valid, 0, "R11 out_valid in reset");
        chk({result, ovf_flag, unf_flag}, 0, "R11 outputs in reset");
        rst_n = 1'b1;

        // Table walk: one operation per cycle; R3 throughput and order
        for (int i = 0; i < NV + 4; i++) begin
            @(negedge clk);
            if (i >= 4) begin
                chk(out_valid, 1, $sformatf("R3 valid row %0d", i - 4));
                chk(result, VEC[i-4].res, $sformatf("R%0d result row %0d", VEC[i-4].req, i - 4));
                chk({ovf_flag, unf_flag}, {VEC[i-4].ovf, VEC[i-4].unf},
                    $sformatf("R%0d flags row %0d", VEC[i-4].req, i - 4));
            end
            if (i < NV) drive(1'b1, VEC[i].sub, VEC[i].a, VEC[i].b);
            else        drive(1'b0, 1'b0, 11'h3BF, 11'h3BF);
        end

        // R12 hold: idle inputs with changing operands must not move outputs
        held = result;
        for (int k = 0; k < 6; k++) begin
            drive(1'b0, k[0], 11'h3BF, 11'h100 + 11'(k));
            @(negedge clk);
            chk({out_valid, result, ovf_flag, unf_flag}, {1'b0, held, 1'b0, 1'b0}, "R12 hold");
        end

        // R3 latency: single pulse of 1.0+1.0
        drive(1'b1, 1'b0, 11'h1C0, 11'h1C0);
        @(negedge clk);
        drive(1'b0, 1'b0, 11'h000, 11'h000);
        for (int k = 1; k <= 5; k++) begin
            if (k > 1) @(negedge clk);
            chk(out_valid, (k == 4) ? 1 : 0, $sformatf("R3 latency cycle %0d", k));
            if (k == 4) chk(result, 11'h200, "R3 latency result");
        end

        // R11 reset mid-flight drops the operation and clears outputs
        drive(1'b1, 1'b0, 11'h3BF, 11'h3BF);
        @(negedge clk);
        drive(1'b0, 1'b0, 11'h000, 11'h000);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk({result, ovf_flag, unf_flag}, 0, "R11 cleared by reset");
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        chk(seen, 0, "R11 in-flight op dropped");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule